// File: doc/BRIEF.md
# MSI Capture Ring Writer

This block takes message-signalled interrupt writes from an inbound port and logs each one as a 16-byte record in a circular buffer in host memory. Each record is issued through a single valid/ready memory write port. The address of a record is the programmed buffer base plus the current hardware write offset. The low 32-bit word of the record holds the message data, and the other 96 bits are zero.

Software sets up the block through a small register file. It programs the 64-bit base, picks one of four buffer sizes from 32 KB to 256 KB, and enables the block. It then consumes records by reading the hardware write offset and moving its own read offset forward. A level interrupt stays high while unread records exist. When the ring is full the block does one of two things, chosen by software: it back-pressures new messages, or it drops them and records the loss in a sticky flag.

Top module: `msi_ring_writer`

## Requirements
- R1: After reset every register reads zero, `irq` and `mem_valid` are low and `msi_ready` is high.
- R2: Register addresses: control 0, base bits 63:32 at 3, base bits 31:0 at 4, software read offset 5, hardware write offset 6 (read-only). Any other address reads zero. Read data shows the addressed register one clock after `reg_addr` is presented.
- R3: A stored message is driven as `mem_addr` = base + write offset and `mem_data` = {96 zero bits, message data}. Both hold steady with `mem_valid` high until `mem_ready`.
- R4: The write offset advances by 16 on each accepted memory write and wraps to zero at the buffer size.
- R5: Control bits 9:8 hold code c, giving a buffer of 2^(15+c) bytes. Offsets are masked with (size − 1) with bits 3:0 cleared, and a written read offset reads back masked.
- R6: The ring is full when (write offset + 16) masked equals the read offset. With control bit 0 (enable) and bit 4 (stop-on-full) set, a full ring holds `msi_ready` low, and it rises once software frees space.
- R7: With stop-on-full clear, a message arriving at a full ring is accepted and dropped with no memory write. Control bit 16 (sticky overflow, write 1 to clear) is then set only if bit 1 (full handling) is set.
- R8: `irq` is high exactly when control bits 0 and 3 are set and the write offset differs from the read offset. It is registered, so it follows one clock after the state changes.
- R9: With control bit 0 clear, inbound messages are accepted and discarded: no memory write is made and the write offset does not move.
- R10: Only one record is in flight: `msi_ready` is low while `mem_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| msi_valid | input | 1 | Inbound message present |
| msi_ready | output | 1 | Inbound message accepted when high with valid |
| msi_data | input | 32 | Inbound message data |
| mem_valid | output | 1 | Record write request |
| mem_ready | input | 1 | Memory accepts the record |
| mem_addr | output | 64 | Record byte address |
| mem_data | output | 128 | Record contents |
| irq | output | 1 | Level interrupt: unread records exist |

## Verification
A long random run sends over two thousand messages with random data into the smallest ring. It uses random `mem_ready` stalls and occasional read-offset updates. This separates correct wrap and offset arithmetic from errors that only show past the buffer end, and it shows whether the record stays stable under back-pressure. Directed cases each target one branch of the acceptance logic: a ring filled to one slot short of the read offset in stall mode and in drop mode, with full handling on and off, and a disabled block. Writes of out-of-range read offsets at different size codes show the mask per size. Each interrupt transition is checked after the read offset catches up, and again when the interrupt enable is cleared.

// File: rtl/msi_ring_pkg.sv
package msi_ring_pkg;
  localparam int SZ_W = 2;

  localparam int CTL_EN      = 0;
  localparam int CTL_FULL_EN = 1;
  localparam int CTL_IRQ_EN  = 3;
  localparam int CTL_STOP    = 4;
  localparam int CTL_SIZE_LO = 8;
  localparam int CTL_OVF     = 16;

  localparam logic [2:0] RA_CTRL    = 3'd0;
  localparam logic [2:0] RA_BASE_HI = 3'd3;
  localparam logic [2:0] RA_BASE_LO = 3'd4;
  localparam logic [2:0] RA_RD_OFF  = 3'd5;
  localparam logic [2:0] RA_WR_OFF  = 3'd6;

  typedef struct packed {
    logic            en;
    logic            full_en;
    logic            irq_en;
    logic            stop;
    logic [SZ_W-1:0] size_code;
  } ring_cfg_t;
endpackage

// File: rtl/msi_ring_regs.sv
module msi_ring_regs
  import msi_ring_pkg::*;
#(
  parameter int REG_AW = 3,
  parameter int ADDR_W = 64,
  parameter int OFF_W  = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              ovf_set,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [OFF_W-1:0]  off_mask,
  output ring_cfg_t         cfg,
  output logic [ADDR_W-1:0] base,
  output logic [OFF_W-1:0]  rd_off
);
  logic ovf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg    <= '0;
      base   <= '0;
      rd_off <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        REG_AW'(RA_CTRL): begin
          cfg.en        <= reg_wdata[CTL_EN];
          cfg.full_en   <= reg_wdata[CTL_FULL_EN];
          cfg.irq_en    <= reg_wdata[CTL_IRQ_EN];
          cfg.stop      <= reg_wdata[CTL_STOP];
          cfg.size_code <= reg_wdata[CTL_SIZE_LO +: SZ_W];
        end
        REG_AW'(RA_BASE_HI): base[ADDR_W-1:32] <= reg_wdata[ADDR_W-33:0];
        REG_AW'(RA_BASE_LO): base[31:0]        <= reg_wdata;
        REG_AW'(RA_RD_OFF):  rd_off            <= reg_wdata[OFF_W-1:0] & off_mask;
        default: ;
      endcase
    end
  end

  // sticky loss flag: a new loss wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst)
      ovf_q <= 1'b0;
    else if (ovf_set)
      ovf_q <= 1'b1;
    else if (reg_we && reg_addr == REG_AW'(RA_CTRL) && reg_wdata[CTL_OVF])
      ovf_q <= 1'b0;
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      REG_AW'(RA_CTRL): begin
        rd_mux[CTL_EN]              = cfg.en;
        rd_mux[CTL_FULL_EN]         = cfg.full_en;
        rd_mux[CTL_IRQ_EN]          = cfg.irq_en;
        rd_mux[CTL_STOP]            = cfg.stop;
        rd_mux[CTL_SIZE_LO +: SZ_W] = cfg.size_code;
        rd_mux[CTL_OVF]             = ovf_q;
      end
      REG_AW'(RA_BASE_HI): rd_mux[ADDR_W-33:0] = base[ADDR_W-1:32];
      REG_AW'(RA_BASE_LO): rd_mux = base[31:0];
      REG_AW'(RA_RD_OFF):  rd_mux[OFF_W-1:0] = rd_off;
      REG_AW'(RA_WR_OFF):  rd_mux[OFF_W-1:0] = wr_off;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/msi_ring_ptr.sv
module msi_ring_ptr
  import msi_ring_pkg::*;
#(
  parameter int MIN_LOG2 = 15,
  parameter int REC_LOG2 = 4,
  parameter int OFF_W    = 18
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SZ_W-1:0] size_code,
  input  logic            advance,
  input  logic [OFF_W-1:0] rd_off,
  output logic [OFF_W-1:0] off_mask,
  output logic [OFF_W-1:0] wr_off,
  output logic            full
);
  localparam logic [OFF_W-1:0] REC_BYTES = OFF_W'(1) << REC_LOG2;

  logic [OFF_W-1:0] wr_q;
  logic [OFF_W-1:0] next_off;

  always_comb begin
    for (int i = 0; i < OFF_W; i++)
      off_mask[i] = (i >= REC_LOG2) && (i < MIN_LOG2 + int'(size_code));
  end

  assign wr_off   = wr_q & off_mask;
  assign next_off = (wr_off + REC_BYTES) & off_mask;
  assign full     = (next_off == (rd_off & off_mask));

  always_ff @(posedge clk) begin
    if (rst)          wr_q <= '0;
    else if (advance) wr_q <= next_off;
  end
endmodule

// File: rtl/msi_ring_wr.sv
module msi_ring_wr
  import msi_ring_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int MSG_W  = 32,
  parameter int REC_W  = 128,
  parameter int OFF_W  = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  ring_cfg_t         cfg,
  input  logic              full,
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic              msi_valid,
  output logic              msi_ready,
  input  logic [MSG_W-1:0]  msi_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [REC_W-1:0]  mem_data,
  output logic              advance,
  output logic              ovf_set
);
  logic stall;
  logic take;

  assign stall     = cfg.en && cfg.stop && full;
  assign msi_ready = !mem_valid && !stall;
  assign take      = msi_valid && msi_ready;
  assign advance   = mem_valid && mem_ready;
  assign ovf_set   = take && cfg.en && full && cfg.full_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
    end else if (advance) begin
      mem_valid <= 1'b0;
    end else if (take && cfg.en && !full) begin
      mem_valid <= 1'b1;
      mem_addr  <= base + ADDR_W'(wr_off);
      mem_data  <= {{(REC_W-MSG_W){1'b0}}, msi_data};
    end
  end
endmodule

// File: rtl/msi_ring_writer.sv
module msi_ring_writer
  import msi_ring_pkg::*;
#(
  parameter int REG_AW   = 3,
  parameter int ADDR_W   = 64,
  parameter int MSG_W    = 32,
  parameter int REC_W    = 128,
  parameter int MIN_LOG2 = 15,
  parameter int REC_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              msi_valid,
  output logic              msi_ready,
  input  logic [MSG_W-1:0]  msi_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [REC_W-1:0]  mem_data,
  output logic              irq
);
  localparam int OFF_W = MIN_LOG2 + (2 ** SZ_W) - 1;

  ring_cfg_t         cfg;
  logic [ADDR_W-1:0] base;
  logic [OFF_W-1:0]  rd_off;
  logic [OFF_W-1:0]  wr_off;
  logic [OFF_W-1:0]  off_mask;
  logic              full;
  logic              advance;
  logic              ovf_set;
  logic              cfg_en;

  assign cfg_en = cfg.en;

  msi_ring_regs #(.REG_AW(REG_AW), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_regs (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ovf_set(ovf_set),
    .wr_off(wr_off), .off_mask(off_mask), .cfg(cfg), .base(base),
    .rd_off(rd_off)
  );

  msi_ring_ptr #(.MIN_LOG2(MIN_LOG2), .REC_LOG2(REC_LOG2), .OFF_W(OFF_W)) u_ptr (
    .clk(clk), .rst(rst), .size_code(cfg.size_code), .advance(advance),
    .rd_off(rd_off), .off_mask(off_mask), .wr_off(wr_off), .full(full)
  );

  msi_ring_wr #(.ADDR_W(ADDR_W), .MSG_W(MSG_W), .REC_W(REC_W), .OFF_W(OFF_W)) u_wr (
    .clk(clk), .rst(rst), .cfg(cfg), .full(full), .base(base),
    .wr_off(wr_off), .msi_valid(msi_valid), .msi_ready(msi_ready),
    .msi_data(msi_data), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .advance(advance),
    .ovf_set(ovf_set)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= cfg_en && cfg.irq_en && (wr_off != (rd_off & off_mask));
  end
endmodule

// File: rtl/msi_ring_checker.sv
module msi_ring_checker #(
  parameter int ADDR_W = 64,
  parameter int MSG_W  = 32,
  parameter int REC_W  = 128,
  parameter int OFF_W  = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              msi_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [REC_W-1:0]  mem_data,
  input logic              irq,
  input logic              en,
  input logic              reg_we,
  input logic [OFF_W-1:0]  wr_off,
  input logic [OFF_W-1:0]  off_mask
);
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

  assert_zero_pad_R3: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> mem_data[REC_W-1:MSG_W] == '0);

  assert_step_R4: assert property (@(posedge clk) disable iff (rst)
    mem_valid && mem_ready && !reg_we |=>
      wr_off == (($past(wr_off) + OFF_W'(16)) & off_mask));

  assert_irq_off_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> !irq);

  assert_one_inflight_R10: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> !msi_ready);
endmodule

bind msi_ring_writer msi_ring_checker #(
  .ADDR_W(ADDR_W), .MSG_W(MSG_W), .REC_W(REC_W), .OFF_W(OFF_W)
) i_chk (
  .clk(clk), .rst(rst), .msi_ready(msi_ready), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
  .irq(irq), .en(cfg_en), .reg_we(reg_we), .wr_off(wr_off),
  .off_mask(off_mask)
);

// File: tb/test_msi_ring_writer.sv
module test_msi_ring_writer;
  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   reg_addr = '0;
  logic         reg_we = 1'b0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         msi_valid = 1'b0;
  logic         msi_ready;
  logic [31:0]  msi_data = '0;
  logic         mem_valid;
  logic         mem_ready = 1'b0;
  logic [63:0]  mem_addr;
  logic [127:0] mem_data;
  logic         irq;

  msi_ring_writer i_msi_ring_writer (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msi_valid(msi_valid),
    .msi_ready(msi_ready), .msi_data(msi_data), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  int unsigned total = 0;
  int unsigned bad   = 0;
  bit          done  = 0;

  // bench model
  logic [63:0] m_base = '0;
  logic [31:0] m_woff = '0, m_roff = '0;
  int          m_code = 0;
  bit          m_en = 0, m_fe = 0, m_stop = 0;
  bit          m_ovf = 0;
  bit          exp_pend = 0;
  logic [31:0] exp_data = '0;
  bit          rand_stall = 0;
  int unsigned wraps = 0;

  function automatic logic [31:0] mfn(int code);
    return ((32'd1 << (15 + code)) - 32'd1) & ~32'hF;
  endfunction

  function automatic logic [31:0] ctl(bit en, bit fe, bit ie, bit st, int code);
    return {22'd0, 2'(code), 3'd0, st, ie, 1'b0, fe, en};
  endfunction

  task automatic check(string tag, bit ok, logic [127:0] act, logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b0;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic set_ctrl(bit en, bit fe, bit ie, bit st, int code, bit clr_ovf);
    logic [31:0] v;
    v = ctl(en, fe, ie, st, code);
    v[16] = clr_ovf;
    reg_write(3'd0, v);
    m_en = en; m_fe = fe; m_stop = st; m_code = code;
    if (clr_ovf) m_ovf = 0;
  endtask

  task automatic set_roff(logic [31:0] v);
    reg_write(3'd5, v);
    m_roff = v & mfn(m_code);
  endtask

  task automatic wait_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  // memory responder and record checker (R3, R4)
  initial begin
    forever begin
      @(negedge clk);
      mem_ready = rand_stall ? 1'($urandom % 2) : 1'b1;
      if (mem_ready && mem_valid) begin
        if (!exp_pend)
          check("R9 unexpected record write", 0, mem_addr, 0);
        else begin
          check("R3 record address", mem_addr == m_base + 64'(m_woff), mem_addr, m_base + 64'(m_woff));
          check("R3 record data", mem_data == {96'd0, exp_data}, mem_data, {96'd0, exp_data});
        end
        if (((m_woff + 32'd16) & mfn(m_code)) == 0) wraps++;
        m_woff   = (m_woff + 32'd16) & mfn(m_code);
        exp_pend = 0;
      end
    end
  end

  task automatic send_msi(logic [31:0] d);
    @(negedge clk);
    msi_valid = 1'b1; msi_data = d;
    while (!msi_ready) @(negedge clk);
    if (m_en) begin
      if (((m_woff + 32'd16) & mfn(m_code)) == m_roff) begin
        if (m_fe) m_ovf = 1;
      end else begin
        exp_pend = 1; exp_data = d;
      end
    end
    @(posedge clk);
    #1 msi_valid = 1'b0;
    while (exp_pend) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state, R2 unmapped address
    @(negedge clk);
    check("R1 irq after reset", irq == 0, irq, 0);
    check("R1 mem_valid after reset", mem_valid == 0, mem_valid, 0);
    check("R1 msi_ready after reset", msi_ready == 1, msi_ready, 1);
    for (int a = 0; a < 8; a++) begin
      reg_read(3'(a), r);
      check("R1 R2 register reads zero", r == 0, r, 0);
    end

    // R2 register map readback
    reg_write(3'd3, 32'h0000_00A5); reg_write(3'd4, 32'h1234_5670);
    m_base = 64'h0000_00A5_1234_5670;
    reg_read(3'd3, r); check("R2 base high", r == 32'hA5, r, 32'hA5);
    reg_read(3'd4, r); check("R2 base low", r == 32'h1234_5670, r, 32'h1234_5670);
    set_ctrl(1, 1, 1, 0, 1, 0);
    reg_read(3'd0, r); check("R2 control readback", r == ctl(1, 1, 1, 0, 1), r, ctl(1, 1, 1, 0, 1));
    reg_write(3'd6, 32'h0000_1230);
    reg_read(3'd6, r); check("R2 write offset read-only", r == 0, r, 0);

    // R5 read offset masking per size code
    set_roff(32'hFFFF_FFFF);
    reg_read(3'd5, r); check("R5 mask 64KB", r == 32'hFFF0, r, 32'hFFF0);
    set_ctrl(1, 1, 1, 0, 3, 0);
    set_roff(32'hFFFF_FFFF);
    reg_read(3'd5, r); check("R5 mask 256KB", r == 32'h3FFF0, r, 32'h3FFF0);
    set_ctrl(1, 1, 1, 0, 0, 0);
    set_roff(32'h0001_2345);
    reg_read(3'd5, r); check("R5 mask 32KB", r == 32'h2340, r, 32'h2340);
    set_roff(32'h0);

    // R3 R8 single record and interrupt
    send_msi(32'hDEAD_0042);
    wait_cycles(2);
    check("R8 irq with unread record", irq == 1, irq, 1);
    reg_read(3'd6, r); check("R4 write offset after one record", r == 32'h10, r, 32'h10);
    set_roff(m_woff);
    wait_cycles(2);
    check("R8 irq clears when caught up", irq == 0, irq, 0);
    send_msi(32'h0000_0007);
    set_ctrl(1, 1, 0, 0, 0, 0);
    wait_cycles(2);
    check("R8 irq masked by irq enable", irq == 0, irq, 1'b0);
    set_ctrl(1, 1, 1, 0, 0, 0);
    wait_cycles(2);
    check("R8 irq returns when re-enabled", irq == 1, irq, 1);

    // R9 disabled block discards
    set_ctrl(0, 1, 1, 0, 0, 0);
    send_msi(32'h5555_AAAA);
    wait_cycles(3);
    reg_read(3'd6, r); check("R9 offset unchanged while disabled", r == m_woff, r, m_woff);
    check("R9 R8 irq low while disabled", irq == 0, irq, 0);

    // R7 drop mode with full handling on, then off
    set_ctrl(1, 1, 1, 0, 0, 0);
    set_roff(m_woff + 32'd32);
    send_msi(32'h0000_1111);
    send_msi(32'h0000_2222);
    reg_read(3'd6, r); check("R7 dropped record leaves offset", r == m_woff, r, m_woff);
    reg_read(3'd0, r); check("R7 overflow flag set", r[16] == 1, r[16], 1);
    set_ctrl(1, 0, 1, 0, 0, 1);
    reg_read(3'd0, r); check("R7 overflow flag cleared", r[16] == 0, r[16], 0);
    send_msi(32'h0000_3333);
    reg_read(3'd0, r); check("R7 no flag without full handling", r[16] == 0, r[16], 0);

    // R6 stop-on-full back-pressure
    set_ctrl(1, 1, 1, 1, 0, 0);
    @(negedge clk);
    msi_valid = 1'b1; msi_data = 32'h0000_4444;
    wait_cycles(6);
    check("R6 msi_ready low when full", msi_ready == 0, msi_ready, 0);
    msi_valid = 1'b0;
    reg_read(3'd6, r); check("R6 offset holds while stalled", r == m_woff, r, m_woff);
    set_roff(m_woff);
    @(negedge clk);
    check("R6 msi_ready after space freed", msi_ready == 1, msi_ready, 1);
    send_msi(32'h0000_4444);

    // random run across the 32KB wrap with stalls (R3 R4 R10)
    rand_stall = 1;
    set_ctrl(1, 1, 1, 0, 0, 1);
    set_roff(m_woff);
    for (int n = 0; n < 2100; n++) begin
      send_msi($urandom);
      if ($urandom % 8 == 0) set_roff(m_woff);
    end
    rand_stall = 0;
    wait_cycles(2);
    reg_read(3'd6, r); check("R4 write offset after random run", r == m_woff, r, m_woff);
    check("R4 ring wrapped", wraps > 0, wraps, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule